// File: doc/BRIEF.md
# Paged Digital I/O Block with Edge Interrupts

This block is a byte-wide register target that serves six 8-bit digital ports inside a 16-byte address window. Each port has an output latch that drives its pad byte. Reading a port returns the pin level after a two-flop synchronizer. A combined page/lock register at offset 0x07 does two things. It holds one protection bit per port, and a locked port ignores writes to its latch. It also selects which of four pages appears at offsets 0x08–0x0A.

The first three ports can raise interrupts. Page 1 at 0x08–0x0A holds a per-bit edge polarity for each of these ports. Page 2 holds a per-bit enable, and page 3 holds a per-bit identification register that latches detected edges. Offset 0x06 summarises which identification registers are nonzero. The single interrupt line is the registered OR of that summary. Software reads the summary, switches to page 3, reads the identification register of the flagged port and writes back a mask to clear the bits it has handled.

Top module: `pdio_irq_ctrl`

## Requirements
- R1: A read of offsets 0x00–0x05 returns the two-flop-synchronized pin byte of port 0–5 on any page. `rdata` is registered: it shows the value one cycle after `rd_en` and is 0x00 in any cycle that follows no read.
- R2: A write to offset 0x00–0x05 loads that port's output latch, which drives `pad_out[8p+7:8p]` from the next cycle, unless the port is locked.
- R3: A write to 0x07 loads the lock bits from `wdata[5:0]`, bit p for port p. While bit p is 1, writes to port p leave `pad_out` for that port unchanged. Clearing the bit makes the port writable again.
- R4: The same write to 0x07 takes the page from `wdata[7:6]`. On page 1, writes to 0x08/0x09/0x0A set the polarity of ports 0/1/2. On page 2 the same writes set the enables. A polarity bit of 1 selects rising edges and 0 selects falling edges.
- R5: An edge of the chosen polarity on a synchronized input bit of ports 0–2 sets the matching identification bit only when its enable bit is 1. Ports 3–5 never raise interrupts.
- R6: On page 3, offsets 0x08–0x0A read the identification registers of ports 0–2. Writing value v there leaves id & v, so writing zero clears the register. Identification bits are otherwise sticky, and an edge that arrives in the same cycle as a clearing write still sets its bit.
- R7: Offset 0x06 reads bit i = 1 when the identification register of port i is nonzero, with bits 7:3 zero. `irq` is the OR of those bits, registered one cycle later.
- R8: Reads return 0x00 from 0x07, from 0x0B–0x0F, and from 0x08–0x0A on pages 0, 1 and 2.
- R9: A synchronous active-high reset clears every output latch, the lock bits, all polarity, enable and identification bits and the synchronizers, and selects page 0. `irq` and `rdata` read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | 4 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pin levels, port p in bits 8p+7:8p |
| pad_out | output | 48 | Output latch values, port p in bits 8p+7:8p |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume reset is held from time zero and that at most one register write happens per cycle. Under that assumption a locked port's output can only stay constant after a write to it. They also assume `pad_in` is free to change at any time, because every check on identification bits is made against the enables of the previous cycle and not against pin timing. The bench drives every strobe and pin change half a cycle away from the sampling edge and issues one access per cycle. In the directed part it holds pin changes long enough to cross the synchronizer, except in the one test that aims an edge at the exact cycle of a clearing write. The random phase changes pins freely and relies on the model to track the synchronizer delay.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_PGLK  = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_PAGED = 4'h8;

  typedef enum logic [1:0] {
    PG_BASE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_IDR  = 2'd3
  } page_e;
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pdio_out_latch.sv
module pdio_out_latch #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            lock,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we && !lock)
      q <= d;
  end
endmodule

// File: rtl/pdio_edge_port.sv
module pdio_edge_port #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] smp,
  input  logic            pol_we,
  input  logic            en_we,
  input  logic            id_we,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] en,
  output logic [BITS-1:0] id
);
  logic [BITS-1:0] pol;
  logic [BITS-1:0] prev;
  logic [BITS-1:0] hit;

  // rising where pol=1, falling where pol=0, gated by enable
  always_comb hit = en & ((pol & smp & ~prev) | (~pol & ~smp & prev));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pol  <= '0;
      en   <= '0;
      id   <= '0;
    end else begin
      prev <= smp;
      if (pol_we) pol <= d;
      if (en_we)  en  <= d;
      id <= (id_we ? (id & d) : id) | hit;
    end
  end
endmodule

// File: rtl/pdio_irq_ctrl.sv
module pdio_irq_ctrl
  import pdio_pkg::*;
#(
  parameter int PORTS     = 6,
  parameter int IRQ_PORTS = 3,
  parameter int BITS      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BITS-1:0]       wdata,
  output logic [BITS-1:0]       rdata,
  input  logic [PORTS*BITS-1:0] pad_in,
  output logic [PORTS*BITS-1:0] pad_out,
  output logic                  irq
);
  localparam int PIN_W = PORTS * BITS;
  localparam int ID_W  = IRQ_PORTS * BITS;

  page_e                 page_q;
  logic [PORTS-1:0]      lock_q;
  logic [PIN_W-1:0]      pin_s;
  logic [ID_W-1:0]       en_all;
  logic [ID_W-1:0]       id_all;
  logic [IRQ_PORTS-1:0]  pend;
  logic [ADDR_W-1:0]     paged_idx;
  logic                  paged_hit;
  logic [BITS-1:0]       rd_val;

  assign paged_idx = addr - OFS_PAGED;
  assign paged_hit = (addr >= OFS_PAGED) && (paged_idx < ADDR_W'(IRQ_PORTS));

  pdio_sync #(.W(PIN_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= PG_BASE;
      lock_q <= '0;
    end else if (wr_en && addr == OFS_PGLK) begin
      page_q <= page_e'(wdata[BITS-1 -: 2]);
      lock_q <= wdata[PORTS-1:0];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    pdio_out_latch #(.BITS(BITS)) u_lat (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && addr == ADDR_W'(p)),
      .lock (lock_q[p]),
      .d    (wdata),
      .q    (pad_out[p*BITS +: BITS])
    );
  end

  for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_irq
    logic sel;
    assign sel = wr_en && paged_hit && paged_idx == ADDR_W'(i);
    pdio_edge_port #(.BITS(BITS)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .smp    (pin_s[i*BITS +: BITS]),
      .pol_we (sel && page_q == PG_POL),
      .en_we  (sel && page_q == PG_ENA),
      .id_we  (sel && page_q == PG_IDR),
      .d      (wdata),
      .en     (en_all[i*BITS +: BITS]),
      .id     (id_all[i*BITS +: BITS])
    );
    assign pend[i] = |id_all[i*BITS +: BITS];
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < PORTS; p++)
      if (addr == ADDR_W'(p)) rd_val = pin_s[p*BITS +: BITS];
    if (addr == OFS_PEND)
      rd_val = BITS'(pend);
    if (paged_hit && page_q == PG_IDR)
      for (int i = 0; i < IRQ_PORTS; i++)
        if (paged_idx == ADDR_W'(i)) rd_val = id_all[i*BITS +: BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_en ? rd_val : '0;
      irq   <= |pend;
    end
  end
endmodule

// File: rtl/pdio_checker.sv
module pdio_checker
  import pdio_pkg::*;
#(
  parameter int PORTS     = 6,
  parameter int IRQ_PORTS = 3,
  parameter int BITS      = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [BITS-1:0]           rdata,
  input logic [PORTS*BITS-1:0]     pad_out,
  input logic                      irq,
  input logic [1:0]                page,
  input logic [PORTS-1:0]          lock,
  input logic [IRQ_PORTS*BITS-1:0] en_all,
  input logic [IRQ_PORTS*BITS-1:0] id_all
);
  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (id_all != '0) |=> irq);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (id_all == '0) |=> !irq);

  assert_new_id_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((id_all & ~$past(id_all) & ~$past(en_all)) == '0));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == OFS_PGLK ||
               addr > OFS_PAGED + ADDR_W'(IRQ_PORTS - 1) ||
               (addr >= OFS_PAGED && page != 2'd3))) |=> (rdata == '0));

  for (genvar p = 0; p < PORTS; p++) begin : g_lock
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(p) && lock[p]) |=>
        (pad_out[p*BITS +: BITS] == $past(pad_out[p*BITS +: BITS])));
  end

  for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_sticky
    assert_id_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && page == 2'd3 && addr == OFS_PAGED + ADDR_W'(i)) |=>
        ((id_all[i*BITS +: BITS] & $past(id_all[i*BITS +: BITS])) ==
          $past(id_all[i*BITS +: BITS])));
  end
endmodule

bind pdio_irq_ctrl pdio_checker #(
  .PORTS(PORTS), .IRQ_PORTS(IRQ_PORTS), .BITS(BITS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .pad_out (pad_out),
  .irq     (irq),
  .page    (page_q),
  .lock    (lock_q),
  .en_all  (en_all),
  .id_all  (id_all)
);

// File: tb/sim_pdio_irq_ctrl.sv
module sim_pdio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pad_in = '0;
  logic [47:0] pad_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [47:0] m_s1, m_s2;
  logic [23:0] m_prev;
  logic [7:0]  m_out [6];
  logic [7:0]  m_pol [3];
  logic [7:0]  m_en  [3];
  logic [7:0]  m_id  [3];
  int          m_page;
  logic [5:0]  m_lock;
  logic [7:0]  m_rdata;
  logic        m_irq;
  string       m_rtag;
  bit          started = 1'b0;

  always @(posedge clk) begin
    logic [7:0] rv;
    logic [7:0] hits [3];
    logic       any_id;
    int         a;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      for (int k = 0; k < 6; k++) m_out[k] = '0;
      for (int k = 0; k < 3; k++) begin m_pol[k] = '0; m_en[k] = '0; m_id[k] = '0; end
      m_page = 0; m_lock = '0; m_rdata = '0; m_irq = 1'b0; m_rtag = "R9";
    end else begin
      a = int'(addr);
      rv = 8'h00;
      m_rtag = "R8";
      if (a < 6) begin rv = m_s2[a*8 +: 8]; m_rtag = "R1"; end
      else if (a == 6) begin
        for (int k = 0; k < 3; k++) rv[k] = (m_id[k] != 0);
        m_rtag = "R7";
      end else if (a >= 8 && a <= 10 && m_page == 3) begin
        rv = m_id[a-8]; m_rtag = "R6";
      end
      any_id = (m_id[0] != 0) || (m_id[1] != 0) || (m_id[2] != 0);
      for (int k = 0; k < 3; k++) begin
        hits[k] = '0;
        for (int b = 0; b < 8; b++) begin
          bit now_v, old_v, fired;
          now_v = m_s2[k*8+b];
          old_v = m_prev[k*8+b];
          fired = m_pol[k][b] ? (now_v && !old_v) : (!now_v && old_v);
          if (fired && m_en[k][b]) hits[k][b] = 1'b1;
        end
      end
      if (wr_en) begin
        if (a < 6) begin
          if (!m_lock[a]) m_out[a] = wdata;
        end else if (a == 7) begin
          m_page = int'(wdata[7:6]);
          m_lock = wdata[5:0];
        end else if (a >= 8 && a <= 10) begin
          if (m_page == 1) m_pol[a-8] = wdata;
          else if (m_page == 2) m_en[a-8] = wdata;
          else if (m_page == 3) m_id[a-8] = m_id[a-8] & wdata;
        end
      end
      for (int k = 0; k < 3; k++) m_id[k] = m_id[k] | hits[k];
      m_prev = m_s2[23:0];
      m_s2 = m_s1;
      m_s1 = pad_in;
      m_rdata = rd_en ? rv : 8'h00;
      m_irq = any_id;
    end
    started = 1'b1;
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 pad_out vs model", pad_out,
          {m_out[5], m_out[4], m_out[3], m_out[2], m_out[1], m_out[0]});
      chk("R7 irq vs model", irq, m_irq);
      chk({m_rtag, " rdata vs model"}, rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 pad_out after reset", pad_out, 48'h0);
    chk("R9 irq after reset", irq, 1'b0);
    rd(4'h8, 8'h00, "R9 page 0 after reset");
    rd(4'h6, 8'h00, "R9 pending after reset");

    wr(4'h0, 8'hA5); wr(4'h5, 8'h3C);
    chk("R2 port0 latch", pad_out[7:0], 8'hA5);
    chk("R2 port5 latch", pad_out[47:40], 8'h3C);

    wr(4'h7, 8'h01); wr(4'h0, 8'hFF);
    chk("R3 locked port0 unchanged", pad_out[7:0], 8'hA5);
    wr(4'h1, 8'h11);
    chk("R3 unlocked port1 written", pad_out[15:8], 8'h11);

    rd(4'h7, 8'h00, "R8 page/lock reads zero");
    rd(4'hF, 8'h00, "R8 unmapped offset");
    rd(4'h8, 8'h00, "R8 page 0 paged slot");

    pad_in[15:8] = 8'h5A; idle(4);
    rd(4'h1, 8'h5A, "R1 port1 input page 0");
    wr(4'h7, 8'h81);
    rd(4'h1, 8'h5A, "R1 port1 input page 2");

    wr(4'h7, 8'h41); wr(4'h8, 8'hFF); wr(4'h9, 8'h00);
    rd(4'h8, 8'h00, "R8 polarity write-only");
    wr(4'h7, 8'h81); wr(4'h8, 8'h0F); wr(4'h9, 8'hFF);
    rd(4'h9, 8'h00, "R8 enable write-only");
    wr(4'h7, 8'hC1);

    pad_in[7:0] = 8'hFF; idle(4);
    rd(4'h8, 8'h0F, "R5 rising edges on enabled bits only");
    rd(4'h6, 8'h01, "R7 pending port0");
    chk("R7 irq high", irq, 1'b1);

    pad_in[15:8] = 8'h00; idle(4);
    rd(4'h9, 8'h5A, "R4 falling polarity on port1");
    rd(4'h6, 8'h03, "R7 pending ports 0 and 1");

    pad_in[23:16] = 8'hFF; pad_in[31:24] = 8'hFF; idle(4);
    rd(4'hA, 8'h00, "R5 port2 disabled");
    rd(4'h6, 8'h03, "R5 port3 never interrupts");

    wr(4'h8, 8'h0C);
    rd(4'h8, 8'h0C, "R6 mask write keeps id & v");
    wr(4'h8, 8'h00);
    rd(4'h8, 8'h00, "R6 zero write clears");
    wr(4'h9, 8'h00); idle(2);
    chk("R7 irq low after clears", irq, 1'b0);
    rd(4'h6, 8'h00, "R7 pending clear");

    pad_in[7:0] = 8'hFE; idle(4);
    rd(4'h8, 8'h00, "R4 falling ignored on rising port");
    pad_in[7:0] = 8'hFF;
    idle(2);
    wr(4'h8, 8'h00);
    rd(4'h8, 8'h01, "R6 edge wins over same-cycle clear");

    wr(4'h7, 8'hC0); wr(4'h0, 8'hFF);
    chk("R3 unlock restores writes", pad_out[7:0], 8'hFF);

    for (int c = 0; c < 3000; c++) begin
      int op;
      wr_en = 1'b0; rd_en = 1'b0;
      rst = (c == 1500);
      op = $urandom_range(0, 9);
      addr = 4'($urandom_range(0, 15));
      wdata = 8'($urandom());
      if (op < 3) wr_en = 1'b1;
      else if (op < 6) rd_en = 1'b1;
      else if (op == 6) pad_in = 48'({$urandom(), $urandom()});
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0; rst = 1'b0;

    rst = 1'b1; idle(1); rst = 1'b0;
    chk("R9 pad_out after late reset", pad_out, 48'h0);
    rd(4'h6, 8'h00, "R9 pending after late reset");
    rd(4'h8, 8'h00, "R9 page 0 selected after late reset");
    idle(2);
    finish_run();
  end
endmodule